// File: doc/BRIEF.md
# Interrupt Event and Mask Register Block

This block collects interrupt causes for a serial-bus link controller and turns them into one processor interrupt line. Single-cycle hardware pulses on `hw_evt_i` latch into a 32-bit pending-event register. A 32-bit enable register selects which pending events may raise `irq_o`. The top bit of the enable register is a global gate.

Software reaches both registers over a plain register bus. Each register has two word addresses. A write to the "set" word turns on every bit written as one. A write to the "clear" word turns off every bit written as one. Bits written as zero are untouched in both cases.

Two bits of the pending register are tied to bus initialization:
- A bus-reset event wipes the self-ID-complete bit.
- While `selfid_phase_i` is high, software cannot clear the bus-reset bit.

Top module: `intr_event_ctrl`

## Requirements
- R1: After synchronous reset, both registers read 0, the global gate (enable bit 31) is 0 and `irq_o` is low.
- R2: A write to offset 0x80 sets the pending bits written as one. A write to offset 0x84 clears the pending bits written as one. Bits written as zero keep their value.
- R3: A write to offset 0x88 sets the enable bits written as one. A write to offset 0x8C clears the enable bits written as one. Bits written as zero keep their value.
- R4: `irq_o` is high exactly when enable bit 31 is 1 and at least one bit position is 1 in both the pending and the enable register. It follows a register change one clock edge after the stimulus.
- R5: While enable bit 31 is 0, `irq_o` stays low whatever the pending and enable bits hold.
- R6: Every read returns its data on `bus_rdata_o` one edge after the read strobe, and the data holds until the next read.
  - Offset 0x84 returns pending AND enable, whatever the value of bit 31.
  - Offset 0x80 returns the raw pending register.
  - Offsets 0x88 and 0x8C both return the enable register.
- R7: A pulse on `hw_evt_i[n]` sets pending bit n. When a pulse and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: A bus-reset event (pending bit 17, from a hardware pulse) clears pending bit 16 (self-ID complete) in the same update. This holds even if bit 16 is being set in that cycle.
- R9: While `selfid_phase_i` is 1, a write to 0x84 leaves bit 17 unchanged. The other bits in that write are still cleared.
- R10: Reserved bits always read 0 and ignore software writes and hardware pulses. For the pending register these are bits 31:27, 18 and 15:10. For the enable register they are bits 30:27, 18 and 15:10.
- R11: A write to any other offset changes nothing, and a read from any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_re_i | input | 1 | Read strobe, one cycle per read |
| bus_rdata_o | output | 32 | Registered read data |
| hw_evt_i | input | 32 | Hardware event pulses, one bit per pending bit |
| selfid_phase_i | input | 1 | High during the self-ID phase of bus initialization |
| irq_o | output | 1 | Processor interrupt request |

## Verification
Every register update lands on the first rising edge after a write strobe or an event pulse. `irq_o` is combinational from the registers, so it changes at that same edge. Read data is captured on the edge after the read strobe.

The bench drives each strobe or pulse on a falling edge and removes it on the next falling edge. It samples `irq_o` and `bus_rdata_o` right at that second falling edge, which is half a period after the result became due.

Collisions need the competing stimuli in one cycle, so the bench drives them together. The cases are an event pulse against a clear write, a bus-reset pulse against a self-ID-complete set, and a clear of bit 17 during the self-ID phase.

// File: rtl/ievt_pkg.sv
package ievt_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    // Bit positions whose function the logic depends on
    localparam int unsigned MASTER_BIT  = 31;
    localparam int unsigned BUSRST_BIT  = 17;
    localparam int unsigned SIDDONE_BIT = 16;

    // Implemented bits: 26:19, 17, 16, 9:0
    localparam logic [REG_W-1:0] EVT_LIVE = 32'h07FB_03FF;
    localparam logic [REG_W-1:0] MSK_LIVE = EVT_LIVE | (32'h1 << MASTER_BIT);

    // Reserved in both registers
    localparam logic [REG_W-1:0] SHARED_RSVD = ~(EVT_LIVE | (32'h1 << MASTER_BIT));

    localparam logic [ADDR_W-1:0] DEF_EVT_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] DEF_MSK_BASE = 8'h88;
    localparam logic [ADDR_W-1:0] CLR_STEP     = 8'h04;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_EVT_RAW = 3'd1,
        SEL_EVT_MSK = 3'd2,
        SEL_MSK     = 3'd3
    } rd_sel_e;

    typedef struct packed {
        logic set_we;
        logic clr_we;
    } wr_pair_t;

    typedef struct packed {
        wr_pair_t evt;
        wr_pair_t msk;
        logic     rd_en;
        rd_sel_e  rd_sel;
    } bus_cmd_t;

    // Select the read source for an offset
    function automatic rd_sel_e pick_source(
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] evt_base,
        input logic [ADDR_W-1:0] msk_base
    );
        rd_sel_e s;
        s = SEL_NONE;
        if (addr == evt_base)                       s = SEL_EVT_RAW;
        else if (addr == evt_base + CLR_STEP)       s = SEL_EVT_MSK;
        else if (addr == msk_base ||
                 addr == msk_base + CLR_STEP)       s = SEL_MSK;
        return s;
    endfunction

endpackage

// File: rtl/ievt_decode.sv
module ievt_decode
    import ievt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EVT_BASE = DEF_EVT_BASE,
    parameter logic [ADDR_W-1:0] MSK_BASE = DEF_MSK_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output bus_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] EVT_CLR = EVT_BASE + CLR_STEP;
    localparam logic [ADDR_W-1:0] MSK_CLR = MSK_BASE + CLR_STEP;

    always_comb begin
        cmd            = '0;
        cmd.evt.set_we = we && (addr == EVT_BASE);
        cmd.evt.clr_we = we && (addr == EVT_CLR);
        cmd.msk.set_we = we && (addr == MSK_BASE);
        cmd.msk.clr_we = we && (addr == MSK_CLR);
        cmd.rd_en      = re;
        cmd.rd_sel     = pick_source(addr, EVT_BASE, MSK_BASE);
    end

endmodule

// File: rtl/ievt_event_reg.sv
module ievt_event_reg
    import ievt_pkg::*;
#(
    parameter int unsigned      W       = REG_W,
    parameter logic [W-1:0]     LIVE    = EVT_LIVE,
    parameter int unsigned      BR_BIT  = BUSRST_BIT,
    parameter int unsigned      SID_BIT = SIDDONE_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_pair_t     sw,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_evt,
    input  logic         selfid_phase,
    output logic [W-1:0] evt_q
);

    localparam logic [W-1:0] HW_CHK = LIVE & ~(W'(1) << SID_BIT);

    logic bus_reset_hit;
    assign bus_reset_hit = hw_evt[BR_BIT];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            localparam bit IS_BR  = (i == BR_BIT);
            localparam bit IS_SID = (i == SID_BIT);
            logic bit_q;
            logic bit_d;
            logic clr_ok;

            // Software may not clear bus-reset during the self-ID phase
            assign clr_ok = !(IS_BR && selfid_phase);

            always_comb begin
                bit_d = bit_q;
                if (sw.set_we && wdata[i])           bit_d = 1'b1;
                if (sw.clr_we && wdata[i] && clr_ok) bit_d = 1'b0;
                if (hw_evt[i])                       bit_d = 1'b1;
                if (IS_SID && bus_reset_hit)         bit_d = 1'b0;
            end

            always_ff @(posedge clk) begin
                if (rst) bit_q <= 1'b0;
                else     bit_q <= bit_d;
            end

            assign evt_q[i] = bit_q;
        end else begin : g_rsvd
            assign evt_q[i] = 1'b0;
        end
    end

    // R7: a hardware pulse always leaves its bit set
    a_r7_hw_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (|(hw_evt & HW_CHK)) |=>
            ((evt_q & $past(hw_evt & HW_CHK)) == $past(hw_evt & HW_CHK)));

    // R8: bus reset wipes self-ID complete and is itself recorded
    a_r8_busreset_wipes_sid: assert property (@(posedge clk) disable iff (rst)
        hw_evt[BR_BIT] |=> (!evt_q[SID_BIT] && evt_q[BR_BIT]));

    // R9: bus-reset bit survives a clear during the self-ID phase
    a_r9_interlock: assert property (@(posedge clk) disable iff (rst)
        (selfid_phase && sw.clr_we && evt_q[BR_BIT]) |=> evt_q[BR_BIT]);

endmodule

// File: rtl/ievt_mask_reg.sv
module ievt_mask_reg
    import ievt_pkg::*;
#(
    parameter int unsigned  W    = REG_W,
    parameter logic [W-1:0] LIVE = MSK_LIVE
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_pair_t     sw,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] msk_q
);

    localparam logic [W-1:0] CHK = LIVE;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)                          bit_q <= 1'b0;
                else if (sw.set_we && wdata[i])   bit_q <= 1'b1;
                else if (sw.clr_we && wdata[i])   bit_q <= 1'b0;
            end
            assign msk_q[i] = bit_q;
        end else begin : g_rsvd
            assign msk_q[i] = 1'b0;
        end
    end

    // R3: set word turns written ones on
    a_r3_set_word: assert property (@(posedge clk) disable iff (rst)
        sw.set_we |=> ((msk_q & $past(wdata & CHK)) == $past(wdata & CHK)));

    // R3: clear word turns written ones off
    a_r3_clear_word: assert property (@(posedge clk) disable iff (rst)
        sw.clr_we |=> ((msk_q & $past(wdata & CHK)) == '0));

    // R3: zero bits keep their value
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (sw.set_we || sw.clr_we) |=>
            ((msk_q & ~$past(wdata)) == ($past(msk_q) & ~$past(wdata))));

endmodule

// File: rtl/ievt_readout.sv
module ievt_readout
    import ievt_pkg::*;
#(
    parameter int unsigned W    = REG_W,
    parameter int unsigned GATE = MASTER_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_cmd_t     cmd,
    input  logic [W-1:0] evt_q,
    input  logic [W-1:0] msk_q,
    output logic [W-1:0] rdata,
    output logic         irq
);

    logic [W-1:0] pend_en;
    logic [W-1:0] rd_mux;

    assign pend_en = evt_q & msk_q;
    assign irq     = msk_q[GATE] && (|pend_en);

    always_comb begin
        unique case (cmd.rd_sel)
            SEL_EVT_RAW: rd_mux = evt_q;
            SEL_EVT_MSK: rd_mux = pend_en;
            SEL_MSK:     rd_mux = msk_q;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (cmd.rd_en) rdata <= rd_mux;
    end

    // R5: the gate bit from the enable register holds the line low
    a_r5_gate_low: assert property (@(posedge clk) disable iff (rst)
        !msk_q[GATE] |-> !irq);

    // R10: reserved positions never appear on the read bus
    a_r10_rsvd_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rdata & SHARED_RSVD[W-1:0]) == '0);

    // R11: unmapped reads return zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd.rd_en && cmd.rd_sel == SEL_NONE) |=> (rdata == '0));

    // R6: read data holds between reads
    a_r6_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !cmd.rd_en |=> $stable(rdata));

endmodule

// File: rtl/intr_event_ctrl.sv
module intr_event_ctrl
    import ievt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] EVT_BASE = DEF_EVT_BASE,
    parameter logic [ADDR_W-1:0] MSK_BASE = DEF_MSK_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    input  logic              bus_we_i,
    input  logic              bus_re_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic [REG_W-1:0]  hw_evt_i,
    input  logic              selfid_phase_i,
    output logic              irq_o
);

    bus_cmd_t         cmd;
    logic [REG_W-1:0] evt_q;
    logic [REG_W-1:0] msk_q;

    ievt_decode #(
        .EVT_BASE (EVT_BASE),
        .MSK_BASE (MSK_BASE)
    ) u_decode (
        .addr (bus_addr_i),
        .we   (bus_we_i),
        .re   (bus_re_i),
        .cmd  (cmd)
    );

    ievt_event_reg #(
        .W       (REG_W),
        .LIVE    (EVT_LIVE),
        .BR_BIT  (BUSRST_BIT),
        .SID_BIT (SIDDONE_BIT)
    ) u_event (
        .clk          (clk),
        .rst          (rst),
        .sw           (cmd.evt),
        .wdata        (bus_wdata_i),
        .hw_evt       (hw_evt_i),
        .selfid_phase (selfid_phase_i),
        .evt_q        (evt_q)
    );

    ievt_mask_reg #(
        .W    (REG_W),
        .LIVE (MSK_LIVE)
    ) u_mask (
        .clk   (clk),
        .rst   (rst),
        .sw    (cmd.msk),
        .wdata (bus_wdata_i),
        .msk_q (msk_q)
    );

    ievt_readout #(
        .W    (REG_W),
        .GATE (MASTER_BIT)
    ) u_readout (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .evt_q (evt_q),
        .msk_q (msk_q),
        .rdata (bus_rdata_o),
        .irq   (irq_o)
    );

    // R1: interrupt line is low on the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !irq_o);

    // R4: line high needs the gate and one enabled pending bit
    a_r4_line_cause: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (msk_q[MASTER_BIT] && ((evt_q & msk_q) != '0)));

endmodule

// File: tb/tb_intr_event_ctrl.sv
module tb_intr_event_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr_i;
    logic [31:0] bus_wdata_i;
    logic        bus_we_i;
    logic        bus_re_i;
    logic [31:0] bus_rdata_o;
    logic [31:0] hw_evt_i;
    logic        selfid_phase_i;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] A_ES = 8'h80;
    localparam logic [7:0] A_EC = 8'h84;
    localparam logic [7:0] A_MS = 8'h88;
    localparam logic [7:0] A_MC = 8'h8C;

    always #5 clk = ~clk;

    intr_event_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .bus_addr_i     (bus_addr_i),
        .bus_wdata_i    (bus_wdata_i),
        .bus_we_i       (bus_we_i),
        .bus_re_i       (bus_re_i),
        .bus_rdata_o    (bus_rdata_o),
        .hw_evt_i       (hw_evt_i),
        .selfid_phase_i (selfid_phase_i),
        .irq_o          (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_re_i = 1'b1;
        @(negedge clk);
        bus_re_i = 1'b0;
        d = bus_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        hw_evt_i = e;
        @(negedge clk);
        hw_evt_i = '0;
    endtask

    task automatic wipe();
        wr(A_EC, 32'hFFFF_FFFF);
        wr(A_MC, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        rd(A_ES, d); check("R1 pending after reset", d, 32'h0);
        rd(A_MS, d); check("R1 enable after reset", d, 32'h0);
    endtask

    task automatic t_event_rw();
        logic [31:0] d;
        wipe();
        wr(A_ES, 32'h0000_0005);
        rd(A_ES, d); check("R2 set word", d, 32'h0000_0005);
        wr(A_EC, 32'h0000_0001);
        rd(A_ES, d); check("R2 clear word", d, 32'h0000_0004);
        wr(A_EC, 32'h0000_0000);
        rd(A_ES, d); check("R2 zero write keeps bits", d, 32'h0000_0004);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        wipe();
        wr(A_MS, 32'h8000_0044);
        rd(A_MS, d); check("R3 set word", d, 32'h8000_0044);
        rd(A_MC, d); check("R6 enable via clear offset", d, 32'h8000_0044);
        wr(A_MC, 32'h8000_0040);
        rd(A_MS, d); check("R3 clear word", d, 32'h0000_0004);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wipe();
        wr(A_MS, 32'h0000_0004);
        wr(A_ES, 32'h0000_0005);
        check("R5 gate off holds irq low", {31'b0, irq_o}, 32'h0);
        rd(A_EC, d); check("R6 masked view, gate off", d, 32'h0000_0004);
        rd(A_ES, d); check("R6 raw view", d, 32'h0000_0005);
        wr(A_MS, 32'h8000_0000);
        check("R4 irq one edge after gate set", {31'b0, irq_o}, 32'h1);
        wr(A_EC, 32'h0000_0004);
        check("R4 irq drops after cause cleared", {31'b0, irq_o}, 32'h0);
        rd(A_EC, d); check("R6 unmasked bit hidden", d, 32'h0);
        pulse(32'h0000_0004);
        check("R4 irq one edge after pulse", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_hw_collide();
        logic [31:0] d;
        wipe();
        pulse(32'h0000_0040);
        rd(A_ES, d); check("R7 pulse sets bit", d, 32'h0000_0040);
        wr(A_ES, 32'h0000_0002);
        @(negedge clk);
        bus_addr_i = A_EC; bus_wdata_i = 32'h0000_0042; bus_we_i = 1'b1;
        hw_evt_i = 32'h0000_0002;
        @(negedge clk);
        bus_we_i = 1'b0; hw_evt_i = '0;
        rd(A_ES, d); check("R7 pulse beats clear", d, 32'h0000_0002);
    endtask

    task automatic t_bus_reset();
        logic [31:0] d;
        wipe();
        wr(A_ES, 32'h0001_0000);
        pulse(32'h0002_0000);
        rd(A_ES, d); check("R8 bus reset wipes self-ID", d, 32'h0002_0000);
        wipe();
        @(negedge clk);
        bus_addr_i = A_ES; bus_wdata_i = 32'h0001_0000; bus_we_i = 1'b1;
        hw_evt_i = 32'h0003_0000;
        @(negedge clk);
        bus_we_i = 1'b0; hw_evt_i = '0;
        rd(A_ES, d); check("R8 bus reset beats self-ID set", d, 32'h0002_0000);
    endtask

    task automatic t_interlock();
        logic [31:0] d;
        wipe();
        pulse(32'h0002_0000);
        wr(A_ES, 32'h0001_0001);
        selfid_phase_i = 1'b1;
        wr(A_EC, 32'h0003_0001);
        rd(A_ES, d); check("R9 bus-reset kept in self-ID phase", d, 32'h0002_0000);
        selfid_phase_i = 1'b0;
        wr(A_EC, 32'h0002_0000);
        rd(A_ES, d); check("R9 clear works after phase", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wipe();
        wr(A_ES, 32'hFFFF_FFFF);
        rd(A_ES, d); check("R10 pending reserved", d, 32'h07FB_03FF);
        wr(A_MS, 32'hFFFF_FFFF);
        rd(A_MS, d); check("R10 enable reserved", d, 32'h87FB_03FF);
        wr(A_EC, 32'hFFFF_FFFF);
        pulse(32'hF804_FC00);
        rd(A_ES, d); check("R10 reserved pulses ignored", d, 32'h0);
        check("R10 no irq from reserved", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wipe();
        wr(A_ES, 32'h0000_0010);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(A_ES, d); check("R11 stray write, pending", d, 32'h0000_0010);
        rd(A_MS, d); check("R11 stray write, enable", d, 32'h0);
        rd(8'h90, d); check("R11 stray read", d, 32'h0);
        rd(A_ES, d);
        @(negedge clk); @(negedge clk);
        check("R6 read data holds", bus_rdata_o, 32'h0000_0010);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        bus_addr_i = '0; bus_wdata_i = '0; bus_we_i = 1'b0; bus_re_i = 1'b0;
        hw_evt_i = '0; selfid_phase_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_event_rw();
        t_mask_rw();
        t_irq();
        t_hw_collide();
        t_bus_reset();
        t_interlock();
        t_reserved();
        t_unmapped();
        finish_run();
    end

endmodule